// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This unit sits between an on-chip AXI master side and a PCIe link and rewrites request addresses on their way out. Software programs up to eight windows through a small word-wide register port. Each window has a control word, an upper size-mask word, a 32-bit AXI base and a 64-bit PCIe base. The control word holds the enable bit, a two-bit type code and the low half of the size mask. The size of a window is held as the bitwise inverse of (size - 1), so one 64-bit mask gives both the region to compare and the bits to replace.

For each request address the unit compares the address with every enabled window in parallel. It picks the lowest-numbered window that matches, replaces the masked upper bits with that window's PCIe base, and returns the translated address, the window number and the window type one clock later. For a configuration-type window it also places the bus, device and function numbers from the window's PCIe low word into address bits 31:16 and reports them on separate outputs. Nothing translates until all four bits of the global enable field are set. A request that finds no window comes back flagged as a miss with its address unchanged.

Top module: `ob_xlate_unit`

## Requirements
- R1: After reset every register reads as zero, every window is disabled, the global enable is off, and `rsp_valid` and `cfg_rd_valid` are low.
- R2: Byte offsets of the registers: window k control at k*16, AXI base at k*16+4, PCIe base low at k*16+8, PCIe base high at k*16+12, upper size mask at 0x80+k*4, global control at 0xC0. A read returns the stored word on `cfg_rd_data` with `cfg_rd_valid` high in the cycle after `cfg_rd_en`.
- R3: Window k matches address A when control bit 0 is set and (A AND M) equals ({32'b0, AXI base} AND M). M is {upper size mask, control[31:12], 12'b0}.
- R4: `rsp_valid` is high in the cycle after `req_valid`, and only then. On a hit to an I/O or memory window, `rsp_addr` = (A AND NOT M) OR ({PCIe high, PCIe low} AND M).
- R5: `rsp_type` reports control bits 2:1 of the selected window: 0 for configuration, 1 for I/O, 2 for memory.
- R6: On a hit to a configuration window, the address is translated as in R4 and then bits 31:16 are replaced by PCIe low bits 31:16. `rsp_bus`, `rsp_dev` and `rsp_fn` equal PCIe low bits 31:24, 23:19 and 18:16. In every other response these three outputs are zero.
- R7: When several windows match, the lowest-numbered one is selected, and its number appears on `rsp_win`.
- R8: No window matches unless bits 3:0 of the global control word are all ones.
- R9: When no window matches, `rsp_miss` is high, `rsp_addr` equals the request address, and `rsp_win` and `rsp_type` are zero.
- R10: Bits 1:0 of an AXI base register are not stored: they read back as zero and have no effect on matching.
- R11: Writes to offsets that are unmapped or not word-aligned change no register. Reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 8 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_addr | input | 8 | Register read byte offset |
| cfg_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| cfg_rd_data | output | 32 | Read data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | AXI-side request address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | 3 | Number of the selected window |
| rsp_type | output | 2 | Type code of the selected window |
| rsp_bus | output | 8 | Bus number for configuration hits |
| rsp_dev | output | 5 | Device number for configuration hits |
| rsp_fn | output | 3 | Function number for configuration hits |

## Verification
A register write takes effect at the clock edge where the strobe is sampled. Read data and translation results are both registered once, so each result is due exactly one cycle after its strobe. The bench raises every strobe at a falling edge and drops it at the next falling edge. It samples the outputs at that same second falling edge, half a period after the edge that loaded the result. Each expected value comes from a register model in the bench that is updated on every write, so a request made right after reprogramming a window or the global enable is checked against the new settings.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;

    localparam int XADDR_W    = 64;
    localparam int WORD_W     = 32;
    localparam int REG_STRIDE = 16;
    localparam int EXT_STRIDE = 4;
    localparam int EXT_BASE   = 'h80;
    localparam int GCTL_OFF   = 'hC0;
    localparam int OFF_CTRL   = 0;
    localparam int OFF_AXIB   = 4;
    localparam int OFF_PLO    = 8;
    localparam int OFF_PHI    = 12;
    localparam int MASK_LSB   = 12;

    typedef enum logic [1:0] {
        WT_CFG  = 2'd0,
        WT_IO   = 2'd1,
        WT_MEM  = 2'd2,
        WT_RSVD = 2'd3
    } win_type_e;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] axi_base;
        logic [WORD_W-1:0] pcie_lo;
        logic [WORD_W-1:0] pcie_hi;
        logic [WORD_W-1:0] size_hi;
    } win_cfg_t;

endpackage

// File: rtl/ob_xlate_regs.sv
module ob_xlate_regs
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic [REG_AW-1:0]            rd_addr,
    output logic                         rd_valid,
    output logic [WORD_W-1:0]            rd_data,
    output win_cfg_t [NUM_WIN-1:0]       win_o,
    output logic                         glob_en_o
);

    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic [WORD_W-1:0]      gctl;
        logic                   rd_valid;
        logic [WORD_W-1:0]      rd_data;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        st_d.rd_data  = '0;

        if (wr_en) begin
            for (int k = 0; k < NUM_WIN; k++) begin
                if (wr_addr == REG_AW'(k * REG_STRIDE + OFF_CTRL))
                    st_d.win[k].ctrl = wr_data;
                if (wr_addr == REG_AW'(k * REG_STRIDE + OFF_AXIB))
                    st_d.win[k].axi_base = {wr_data[WORD_W-1:2], 2'b00};
                if (wr_addr == REG_AW'(k * REG_STRIDE + OFF_PLO))
                    st_d.win[k].pcie_lo = wr_data;
                if (wr_addr == REG_AW'(k * REG_STRIDE + OFF_PHI))
                    st_d.win[k].pcie_hi = wr_data;
                if (wr_addr == REG_AW'(EXT_BASE + k * EXT_STRIDE))
                    st_d.win[k].size_hi = wr_data;
            end
            if (wr_addr == REG_AW'(GCTL_OFF))
                st_d.gctl = wr_data;
        end

        if (rd_en) begin
            for (int k = 0; k < NUM_WIN; k++) begin
                if (rd_addr == REG_AW'(k * REG_STRIDE + OFF_CTRL))
                    st_d.rd_data = st_q.win[k].ctrl;
                if (rd_addr == REG_AW'(k * REG_STRIDE + OFF_AXIB))
                    st_d.rd_data = st_q.win[k].axi_base;
                if (rd_addr == REG_AW'(k * REG_STRIDE + OFF_PLO))
                    st_d.rd_data = st_q.win[k].pcie_lo;
                if (rd_addr == REG_AW'(k * REG_STRIDE + OFF_PHI))
                    st_d.rd_data = st_q.win[k].pcie_hi;
                if (rd_addr == REG_AW'(EXT_BASE + k * EXT_STRIDE))
                    st_d.rd_data = st_q.win[k].size_hi;
            end
            if (rd_addr == REG_AW'(GCTL_OFF))
                st_d.rd_data = st_q.gctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign win_o     = st_q.win;
    assign glob_en_o = &st_q.gctl[3:0];

endmodule

// File: rtl/ob_xlate_match.sv
module ob_xlate_match
    import ob_xlate_pkg::*;
(
    input  win_cfg_t             cfg,
    input  logic [XADDR_W-1:0]   addr,
    output logic                 hit,
    output logic [XADDR_W-1:0]   xaddr,
    output logic [1:0]           typ
);

    logic [XADDR_W-1:0] mask;
    logic [XADDR_W-1:0] abase;
    logic [XADDR_W-1:0] pbase;
    logic               unused_bits;

    assign mask  = {cfg.size_hi, cfg.ctrl[WORD_W-1:MASK_LSB], {MASK_LSB{1'b0}}};
    assign abase = {{(XADDR_W-WORD_W){1'b0}}, cfg.axi_base[WORD_W-1:2], 2'b00};
    assign pbase = {cfg.pcie_hi, cfg.pcie_lo};
    assign typ   = cfg.ctrl[2:1];
    assign unused_bits = ^{cfg.ctrl[MASK_LSB-1:3], cfg.axi_base[1:0]};

    always_comb begin
        hit   = cfg.ctrl[0] && ((addr & mask) == (abase & mask));
        xaddr = (addr & ~mask) | (pbase & mask);
        if (typ == WT_CFG)
            xaddr[31:16] = cfg.pcie_lo[31:16];
    end

endmodule

// File: rtl/ob_xlate_pick.sv
module ob_xlate_pick #(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               found,
    output logic [WIN_W-1:0]   sel
);

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (hits[k]) begin
                found = 1'b1;
                sel   = WIN_W'(k);
            end
        end
    end

endmodule

// File: rtl/ob_xlate_unit.sv
module ob_xlate_unit
    import ob_xlate_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int REG_AW  = 8,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [REG_AW-1:0]    cfg_wr_addr,
    input  logic [31:0]          cfg_wr_data,
    input  logic                 cfg_rd_en,
    input  logic [REG_AW-1:0]    cfg_rd_addr,
    output logic                 cfg_rd_valid,
    output logic [31:0]          cfg_rd_data,
    input  logic                 req_valid,
    input  logic [63:0]          req_addr,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_addr,
    output logic                 rsp_miss,
    output logic [WIN_W-1:0]     rsp_win,
    output logic [1:0]           rsp_type,
    output logic [7:0]           rsp_bus,
    output logic [4:0]           rsp_dev,
    output logic [2:0]           rsp_fn
);

    typedef struct packed {
        logic               valid;
        logic               miss;
        logic [63:0]        addr;
        logic [WIN_W-1:0]   win;
        logic [1:0]         typ;
        logic [7:0]         bus;
        logic [4:0]         dev;
        logic [2:0]         fn;
    } rsp_t;

    win_cfg_t [NUM_WIN-1:0] win_cfg;
    logic                   glob_en;
    logic [NUM_WIN-1:0]     hit_raw;
    logic [NUM_WIN-1:0]     hit_gated;
    logic [63:0]            xl_addr [NUM_WIN];
    logic [1:0]             xl_typ  [NUM_WIN];
    logic                   found;
    logic [WIN_W-1:0]       sel;
    rsp_t                   rsp_d, rsp_q;

    ob_xlate_regs #(
        .NUM_WIN (NUM_WIN),
        .REG_AW  (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_addr   (cfg_wr_addr),
        .wr_data   (cfg_wr_data),
        .rd_en     (cfg_rd_en),
        .rd_addr   (cfg_rd_addr),
        .rd_valid  (cfg_rd_valid),
        .rd_data   (cfg_rd_data),
        .win_o     (win_cfg),
        .glob_en_o (glob_en)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        ob_xlate_match u_match (
            .cfg   (win_cfg[g]),
            .addr  (req_addr),
            .hit   (hit_raw[g]),
            .xaddr (xl_addr[g]),
            .typ   (xl_typ[g])
        );
    end

    assign hit_gated = hit_raw & {NUM_WIN{glob_en}};

    ob_xlate_pick #(
        .NUM_WIN (NUM_WIN)
    ) u_pick (
        .hits  (hit_gated),
        .found (found),
        .sel   (sel)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.miss  = 1'b1;
        rsp_d.addr  = req_addr;
        if (req_valid && found) begin
            rsp_d.miss = 1'b0;
            rsp_d.win  = sel;
            rsp_d.typ  = xl_typ[sel];
            rsp_d.addr = xl_addr[sel];
            if (xl_typ[sel] == WT_CFG) begin
                rsp_d.bus = win_cfg[sel].pcie_lo[31:24];
                rsp_d.dev = win_cfg[sel].pcie_lo[23:19];
                rsp_d.fn  = win_cfg[sel].pcie_lo[18:16];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_win   = rsp_q.win;
    assign rsp_type  = rsp_q.typ;
    assign rsp_bus   = rsp_q.bus;
    assign rsp_dev   = rsp_q.dev;
    assign rsp_fn    = rsp_q.fn;

endmodule

// File: rtl/ob_xlate_unit_chk.sv
module ob_xlate_unit_chk #(
    parameter int WIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_rd_en,
    input logic              cfg_rd_valid,
    input logic              req_valid,
    input logic [63:0]       req_addr,
    input logic              glob_en,
    input logic              rsp_valid,
    input logic [63:0]       rsp_addr,
    input logic              rsp_miss,
    input logic [WIN_W-1:0]  rsp_win,
    input logic [1:0]        rsp_type,
    input logic [7:0]        rsp_bus,
    input logic [4:0]        rsp_dev,
    input logic [2:0]        rsp_fn
);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> cfg_rd_valid); // R2

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R4

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R4

    AST_CFG_BDF_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_miss && rsp_type == 2'd0)
            |-> rsp_addr[31:16] == {rsp_bus, rsp_dev, rsp_fn}); // R6

    AST_BDF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_miss || rsp_type != 2'd0))
            |-> (rsp_bus == 8'd0 && rsp_dev == 5'd0 && rsp_fn == 3'd0)); // R6

    AST_GATE_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !glob_en) |=> rsp_miss); // R8

    AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> rsp_addr == $past(req_addr)); // R9

    AST_MISS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> (rsp_win == '0 && rsp_type == 2'd0)); // R9

endmodule

bind ob_xlate_unit ob_xlate_unit_chk #(
    .WIN_W (WIN_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rd_en    (cfg_rd_en),
    .cfg_rd_valid (cfg_rd_valid),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .glob_en      (glob_en),
    .rsp_valid    (rsp_valid),
    .rsp_addr     (rsp_addr),
    .rsp_miss     (rsp_miss),
    .rsp_win      (rsp_win),
    .rsp_type     (rsp_type),
    .rsp_bus      (rsp_bus),
    .rsp_dev      (rsp_dev),
    .rsp_fn       (rsp_fn)
);

// File: tb/ob_xlate_unit_test.sv
`timescale 1ns/1ps
module ob_xlate_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        cfg_rd_en = 1'b0;
    logic [7:0]  cfg_rd_addr = '0;
    logic        cfg_rd_valid;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_miss;
    logic [2:0]  rsp_win;
    logic [1:0]  rsp_type;
    logic [7:0]  rsp_bus;
    logic [4:0]  rsp_dev;
    logic [2:0]  rsp_fn;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] m_ctrl [8];
    logic [31:0] m_axib [8];
    logic [31:0] m_plo  [8];
    logic [31:0] m_phi  [8];
    logic [31:0] m_ext  [8];
    logic [31:0] m_gctl;

    logic        e_miss;
    logic [63:0] e_addr;
    logic [2:0]  e_win;
    logic [1:0]  e_type;
    logic [7:0]  e_bus;
    logic [4:0]  e_dev;
    logic [2:0]  e_fn;

    always #10 clk = ~clk;

    ob_xlate_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_addr  (cfg_wr_addr),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_rd_en    (cfg_rd_en),
        .cfg_rd_addr  (cfg_rd_addr),
        .cfg_rd_valid (cfg_rd_valid),
        .cfg_rd_data  (cfg_rd_data),
        .req_valid    (req_valid),
        .req_addr     (req_addr),
        .rsp_valid    (rsp_valid),
        .rsp_addr     (rsp_addr),
        .rsp_miss     (rsp_miss),
        .rsp_win      (rsp_win),
        .rsp_type     (rsp_type),
        .rsp_bus      (rsp_bus),
        .rsp_dev      (rsp_dev),
        .rsp_fn       (rsp_fn)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        if (a < 8'h80) begin
            case (a[3:2])
                2'd0: return m_ctrl[a[6:4]];
                2'd1: return m_axib[a[6:4]];
                2'd2: return m_plo[a[6:4]];
                default: return m_phi[a[6:4]];
            endcase
        end
        if (a >= 8'h80 && a < 8'hA0) return m_ext[a[4:2]];
        if (a == 8'hC0) return m_gctl;
        return 32'h0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        if (a < 8'h80) begin
            case (a[3:2])
                2'd0: m_ctrl[a[6:4]] = d;
                2'd1: m_axib[a[6:4]] = d & 32'hFFFF_FFFC;
                2'd2: m_plo[a[6:4]]  = d;
                default: m_phi[a[6:4]] = d;
            endcase
        end else if (a >= 8'h80 && a < 8'hA0) begin
            m_ext[a[4:2]] = d;
        end else if (a == 8'hC0) begin
            m_gctl = d;
        end
    endtask

    task automatic predict(input logic [63:0] a);
        logic [63:0] msk;
        logic [63:0] bas;
        logic [63:0] pb;
        e_miss = 1'b1; e_addr = a; e_win = '0; e_type = '0;
        e_bus = '0; e_dev = '0; e_fn = '0;
        if (m_gctl[3:0] == 4'hF) begin
            for (int k = 7; k >= 0; k--) begin
                msk = {m_ext[k], m_ctrl[k][31:12], 12'h000};
                bas = {32'h0, m_axib[k]};
                pb  = {m_phi[k], m_plo[k]};
                if (m_ctrl[k][0] && ((a & msk) == (bas & msk))) begin
                    e_miss = 1'b0;
                    e_win  = 3'(k);
                    e_type = m_ctrl[k][2:1];
                    e_addr = (a & ~msk) | (pb & msk);
                    e_bus = '0; e_dev = '0; e_fn = '0;
                    if (e_type == 2'd0) begin
                        e_addr[31:16] = m_plo[k][31:16];
                        e_bus = m_plo[k][31:24];
                        e_dev = m_plo[k][23:19];
                        e_fn  = m_plo[k][18:16];
                    end
                end
            end
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_rd_check(input string req, input logic [7:0] a);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_rd_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        check(req, "rd_valid", 64'(cfg_rd_valid), 64'd1);
        check(req, $sformatf("rd_data@%h", a), 64'(cfg_rd_data), 64'(model_read(a)));
    endtask

    task automatic xlate_check(input string req, input logic [63:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        predict(a);
        check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(req, "rsp_miss", 64'(rsp_miss), 64'(e_miss));
        check(req, "rsp_addr", rsp_addr, e_addr);
        check(req, "rsp_win", 64'(rsp_win), 64'(e_win));
        check(req, "rsp_type", 64'(rsp_type), 64'(e_type));
        check(req, "rsp_bdf", 64'({rsp_bus, rsp_dev, rsp_fn}), 64'({e_bus, e_dev, e_fn}));
    endtask

    task automatic set_window(input int k, input logic [31:0] ctrl, input logic [31:0] ext,
                              input logic [31:0] axib, input logic [31:0] lo, input logic [31:0] hi);
        reg_wr(8'(k * 16 + 0), ctrl);
        reg_wr(8'(k * 16 + 4), axib);
        reg_wr(8'(k * 16 + 8), lo);
        reg_wr(8'(k * 16 + 12), hi);
        reg_wr(8'(8'h80 + k * 4), ext);
    endtask

    task automatic t_reset;
        check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1", "rd_valid after reset", 64'(cfg_rd_valid), 64'd0);
        reg_rd_check("R1", 8'h00);
        reg_rd_check("R1", 8'h84);
        reg_rd_check("R1", 8'hC0);
        xlate_check("R1", 64'h0000_0000_4000_0000);
        check("R1", "miss when idle", 64'(rsp_miss), 64'd1);
        @(negedge clk);
        check("R4", "rsp_valid drops", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_regmap;
        reg_wr(8'h30, 32'hABCD_EF00);
        reg_wr(8'h34, 32'h1234_5677);
        reg_wr(8'h38, 32'h5555_AAAA);
        reg_wr(8'h3C, 32'h0000_00FE);
        reg_wr(8'h8C, 32'hFFFF_FFF0);
        reg_rd_check("R2", 8'h30);
        reg_rd_check("R10", 8'h34);
        check("R10", "axi base low bits", 64'(cfg_rd_data), 64'h1234_5674);
        reg_rd_check("R2", 8'h38);
        reg_rd_check("R2", 8'h3C);
        reg_rd_check("R2", 8'h8C);
        reg_wr(8'hA0, 32'hDEAD_BEEF);
        reg_wr(8'hC4, 32'hDEAD_BEEF);
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd_check("R11", 8'hA0);
        reg_rd_check("R11", 8'hC4);
        reg_rd_check("R11", 8'h00);
        check("R11", "win0 ctrl untouched", 64'(cfg_rd_data), 64'h0);
        reg_rd_check("R11", 8'h01);
    endtask

    task automatic t_global;
        set_window(2, 32'hFFFF_0005, 32'hFFFF_FFFF, 32'h4000_0000, 32'h2345_0000, 32'h0000_0001);
        reg_wr(8'hC0, 32'h0000_0007);
        reg_rd_check("R2", 8'hC0);
        xlate_check("R8", 64'h0000_0000_4000_1234);
        check("R8", "partial enable misses", 64'(rsp_miss), 64'd1);
        reg_wr(8'hC0, 32'h0000_000F);
        xlate_check("R8", 64'h0000_0000_4000_1234);
        check("R8", "full enable hits", 64'(rsp_miss), 64'd0);
    endtask

    task automatic t_mem;
        xlate_check("R4", 64'h0000_0000_4000_FFFC);
        check("R4", "mem translation", rsp_addr, 64'h0000_0001_2345_FFFC);
        xlate_check("R5", 64'h0000_0000_4000_0010);
        xlate_check("R9", 64'h0000_0000_4001_0000);
        xlate_check("R3", 64'h0000_0001_4000_0010);
        check("R3", "upper mask compare", 64'(rsp_miss), 64'd1);
    endtask

    task automatic t_io;
        set_window(4, 32'hFFFF_F003, 32'hFFFF_FFFF, 32'h5000_0003, 32'h0000_A000, 32'h0);
        xlate_check("R10", 64'h0000_0000_5000_0ABC);
        check("R5", "io type", 64'(rsp_type), 64'd1);
        check("R4", "io translation", rsp_addr, 64'h0000_0000_0000_AABC);
        xlate_check("R3", 64'h0000_0000_5000_1000);
    endtask

    task automatic t_cfg;
        set_window(0, 32'hFFF0_0001, 32'hFFFF_FFFF, 32'h6000_0000, 32'h122B_0000, 32'h0);
        xlate_check("R6", 64'h0000_0000_6000_0F04);
        check("R6", "cfg address", rsp_addr, 64'h0000_0000_122B_0F04);
        check("R6", "cfg bus", 64'(rsp_bus), 64'h12);
        check("R6", "cfg dev", 64'(rsp_dev), 64'd5);
        check("R6", "cfg fn", 64'(rsp_fn), 64'd3);
        xlate_check("R6", 64'h0000_0000_600F_FFF8);
    endtask

    task automatic t_priority;
        set_window(1, 32'hFF00_0005, 32'hFFFF_FFFF, 32'h7000_0000, 32'hA000_0000, 32'h0);
        set_window(5, 32'hF000_0005, 32'hFFFF_FFFF, 32'h7000_0000, 32'hB000_0000, 32'h0);
        xlate_check("R7", 64'h0000_0000_7000_0040);
        check("R7", "lowest window wins", 64'(rsp_win), 64'd1);
        xlate_check("R7", 64'h0000_0000_7100_0000);
        check("R7", "only upper window", 64'(rsp_win), 64'd5);
        reg_wr(8'h10, 32'hFF00_0004);
        xlate_check("R7", 64'h0000_0000_7000_0040);
        check("R7", "after disable", 64'(rsp_win), 64'd5);
    endtask

    task automatic t_large;
        set_window(6, 32'h0000_0005, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0000_0040);
        xlate_check("R3", 64'h0000_0001_2345_6789);
        check("R3", "wide window", rsp_addr, 64'h0000_0041_2345_6789);
        xlate_check("R9", 64'h0000_0002_0000_0000);
        xlate_check("R4", 64'h0000_0000_4000_0020);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_ctrl[k] = '0; m_axib[k] = '0; m_plo[k] = '0; m_phi[k] = '0; m_ext[k] = '0;
        end
        m_gctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_global;
        t_mem;
        t_io;
        t_cfg;
        t_priority;
        t_large;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule